// File: doc/BRIEF.md
# Pixel unpacker with palette lookup

This block sits between a stream of 32-bit frame-buffer words and a display output stage. Each word arrives through a valid/ready handshake. The block cuts the word into pixels of 1, 2, 4, 8, 16 or 24 bits and sends one 24-bit RGB pixel per handshake on its output stream.

Narrow pixels (8 bits and below) are colour indices. Each index selects a 16-bit entry in an on-chip palette, and that entry is widened to 8 bits per channel. Wide pixels (16 and 24 bits) carry their colour directly and skip the palette.

Software loads and reads the palette through a separate host port. The palette is organised as words that each hold two entries. Byte order, pixel order inside a byte, and a red/blue exchange can each be chosen on their own. The configuration inputs are expected to be held steady while pixels are in flight.

Top module: `pix_unpack`

## Requirements
- R1: `cfgBppSel` selects the pixel size: 0=1 bit, 1=2 bits, 2=4 bits, 3=8 bits, 4=16 bits, 5 (and 6, 7)=24 bits. A word yields 32, 16, 8, 4, 2 or 1 pixels respectively, and pixels are emitted in the order in which they are extracted from the (possibly byte-reversed) word.
- R2: With `cfgByteBig`=0, byte n of a word is bits [8n+7:8n]. With `cfgByteBig`=1, the four bytes are reversed before unpacking, so byte n is bits [31-8n:24-8n]. The k-th 8-bit pixel is byte k, and the k-th 16-bit pixel is the half-word at bit 16k of the reordered word.
- R3: For sub-byte pixels, with `cfgPixBig`=0 the first pixel of each byte is its least significant bits. With `cfgPixBig`=1 the first pixel is its most significant bits. `cfgPixBig` has no effect at 8, 16 or 24 bits per pixel.
- R4: At 1, 2, 4 and 8 bits per pixel, the pixel value is a palette index i. The entry used is the low half-word [15:0] of palette word i/2 when i is even, and the high half-word [31:16] when i is odd.
- R5: A 16-bit colour value holds red in [4:0], green in [9:5] and blue in [14:10]; bit 15 is ignored. Each 5-bit field c is widened to 8 bits as {c, c[4:2]}. `pixData` carries red in [23:16], green in [15:8] and blue in [7:0].
- R6: At 16 bits per pixel, the pixel is a direct colour value in the R5 layout, and the palette is not used.
- R7: At 24 bits per pixel, red comes from bits [7:0], green from [15:8] and blue from [23:16] of the reordered word. Bits [31:24] are ignored.
- R8: With `cfgSwapRB`=1, the red and blue channels of `pixData` are exchanged.
- R9: A host write with `palWrEn`=1 stores `palWrData` at palette word `palAddr`. `palRdData` shows the word at the `palAddr` presented at the previous clock edge.
- R10: An input word is accepted only after all pixels of the previous word have entered the output stage. While `pixValid` is 1 and `pixReady` is 0, `pixValid` and `pixData` hold. No pixel is lost or repeated.
- R11: After reset, `pixValid` is 0 and `inReady` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgBppSel | input | 3 | Pixel size select |
| cfgByteBig | input | 1 | Reverse byte order within the word |
| cfgPixBig | input | 1 | First sub-byte pixel taken from the byte's high bits |
| cfgSwapRB | input | 1 | Exchange red and blue at the output |
| inData | input | 32 | Packed input word |
| inValid | input | 1 | Input word available |
| inReady | output | 1 | Input word accepted this cycle when valid |
| palWrEn | input | 1 | Host palette write strobe |
| palAddr | input | 7 | Host palette word address |
| palWrData | input | 32 | Host palette write data (two entries) |
| palRdData | output | 32 | Host palette read data, one cycle latency |
| pixData | output | 24 | Output pixel, red/green/blue |
| pixValid | output | 1 | Output pixel available |
| pixReady | input | 1 | Downstream accepts the pixel |

## Verification
Every pixel size is run with every combination of byte order, pixel order and red/blue swap. The input words are hashed, and every emitted pixel is compared with a value the bench computes arithmetically.

Comparing the sub-byte modes against the 8-bit and wider modes under both pixel orders shows whether the pixel-order bit is confined to sub-byte pixels. Comparing the byte orders separates byte reversal from pixel reversal. Every palette word holds distinct halves, so odd and even indices are told apart. Irregular input-valid and output-ready patterns expose lost, duplicated or early-popped pixels. A full palette write and read-back checks the host port.

// File: rtl/pix_unpack_pkg.sv
package pix_unpack_pkg;
  localparam int WORD_W = 32;
  localparam int PIX_IDX_W = $clog2(WORD_W);
  localparam int SRC_CH_W = 5;
  localparam int OUT_CH_W = 8;
  localparam int OUT_W = 3 * OUT_CH_W;

  typedef struct packed {
    logic                 loadWord;
    logic                 stepPix;
    logic [PIX_IDX_W-1:0] pixIdx;
  } ctlStrobe_t;

  // log2 of the pixel size; 5 stands for the 24-bit mode
  function automatic logic [2:0] bppLog(input logic [2:0] sel);
    return (sel > 3'd4) ? 3'd5 : sel;
  endfunction

  function automatic logic [OUT_CH_W-1:0] widenCh(input logic [SRC_CH_W-1:0] c);
    return {c, c[SRC_CH_W-1 -: OUT_CH_W-SRC_CH_W]};
  endfunction
endpackage

// File: rtl/pix_unpack_ctrl.sv
module pix_unpack_ctrl
  import pix_unpack_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] cfgBppSel,
  input  logic       inValid,
  output logic       inReady,
  input  logic       pixReady,
  output logic       pixValid,
  output ctlStrobe_t strb
);
  logic                 wordValid;
  logic                 s1Valid;
  logic [PIX_IDX_W-1:0] pixIdx;
  logic [PIX_IDX_W-1:0] lastIdx;
  logic                 advance;
  logic                 step;
  logic                 lastPix;
  logic                 load;
  logic [PIX_IDX_W:0]   perWord;

  always_comb begin
    perWord = (cfgBppSel > 3'd4) ? (PIX_IDX_W+1)'(1)
                                 : (PIX_IDX_W+1)'(WORD_W >> cfgBppSel);
    lastIdx = PIX_IDX_W'(perWord - 1'b1);
  end

  assign advance  = !s1Valid || pixReady;
  assign step     = wordValid && advance;
  assign lastPix  = (pixIdx == lastIdx);
  assign inReady  = !wordValid || (step && lastPix);
  assign load     = inValid && inReady;
  assign pixValid = s1Valid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordValid <= 1'b0;
      pixIdx    <= '0;
      s1Valid   <= 1'b0;
    end else begin
      if (load) begin
        wordValid <= 1'b1;
        pixIdx    <= '0;
      end else if (step && lastPix) begin
        wordValid <= 1'b0;
      end else if (step) begin
        pixIdx <= pixIdx + 1'b1;
      end
      if (advance) s1Valid <= wordValid;
    end
  end

  assign strb.loadWord = load;
  assign strb.stepPix  = step;
  assign strb.pixIdx   = pixIdx;
endmodule

// File: rtl/pix_unpack_dp.sv
module pix_unpack_dp
  import pix_unpack_pkg::*;
#(
  parameter int IDX_W = 8,
  localparam int PAL_AW = IDX_W - 1,
  localparam int PAL_WORDS = 1 << PAL_AW
) (
  input  logic              clk,
  input  logic [2:0]        cfgBppSel,
  input  logic              cfgByteBig,
  input  logic              cfgPixBig,
  input  logic              cfgSwapRB,
  input  logic [WORD_W-1:0] inData,
  input  ctlStrobe_t        strb,
  input  logic              palWrEn,
  input  logic [PAL_AW-1:0] palAddr,
  input  logic [WORD_W-1:0] palWrData,
  output logic [WORD_W-1:0] palRdData,
  output logic [OUT_W-1:0]  pixData
);
  localparam int BYTES = WORD_W / 8;
  localparam int HALF_W = WORD_W / 2;

  logic [WORD_W-1:0]    wordQ;
  logic [WORD_W-1:0]    ordered;
  logic [WORD_W-1:0]    shifted;
  logic [2:0]           lg;
  logic                 subByte;
  logic [PIX_IDX_W-1:0] bitOff;
  logic [IDX_W-1:0]     idxMask;
  logic [IDX_W-1:0]     rawIdx;
  logic [OUT_W-1:0]     trueRgb;

  logic [WORD_W-1:0]    palMem [PAL_WORDS];
  logic [WORD_W-1:0]    lkData;
  logic                 s1Pal;
  logic                 s1Odd;
  logic [OUT_W-1:0]     s1True;
  logic [HALF_W-1:0]    entry;
  logic [OUT_W-1:0]     palRgb;
  logic [OUT_W-1:0]     rgb;

  always_ff @(posedge clk) begin
    if (strb.loadWord) wordQ <= inData;
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_byteOrd
    assign ordered[8*b +: 8] = cfgByteBig ? wordQ[8*(BYTES-1-b) +: 8] : wordQ[8*b +: 8];
  end

  always_comb begin
    lg      = bppLog(cfgBppSel);
    subByte = (cfgBppSel < 3'd3);
    bitOff  = PIX_IDX_W'(strb.pixIdx << lg);
    if (cfgPixBig && subByte)
      bitOff = bitOff ^ PIX_IDX_W'(8 - (1 << lg));
    shifted = ordered >> bitOff;
    idxMask = subByte ? IDX_W'((1 << (1 << lg)) - 1) : '1;
    rawIdx  = shifted[IDX_W-1:0] & idxMask;
    if (lg == 3'd4)
      trueRgb = {widenCh(shifted[4:0]), widenCh(shifted[9:5]), widenCh(shifted[14:10])};
    else
      trueRgb = {ordered[7:0], ordered[15:8], ordered[23:16]};
  end

  always_ff @(posedge clk) begin
    if (palWrEn) palMem[palAddr] <= palWrData;
    palRdData <= palMem[palAddr];
    if (strb.stepPix) begin
      lkData <= palMem[rawIdx[IDX_W-1:1]];
      s1Odd  <= rawIdx[0];
      s1Pal  <= (cfgBppSel < 3'd4);
      s1True <= trueRgb;
    end
  end

  assign entry = s1Odd ? lkData[WORD_W-1:HALF_W] : lkData[HALF_W-1:0];

  for (genvar c = 0; c < 3; c++) begin : g_chan
    // channel c of the entry (red first) lands in output slot 2-c
    assign palRgb[OUT_CH_W*(2-c) +: OUT_CH_W] = widenCh(entry[SRC_CH_W*c +: SRC_CH_W]);
  end

  assign rgb     = s1Pal ? palRgb : s1True;
  assign pixData = cfgSwapRB ? {rgb[7:0], rgb[15:8], rgb[23:16]} : rgb;
endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
  import pix_unpack_pkg::*;
#(
  parameter int IDX_W = 8,
  localparam int PAL_AW = IDX_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cfgBppSel,
  input  logic              cfgByteBig,
  input  logic              cfgPixBig,
  input  logic              cfgSwapRB,
  input  logic [WORD_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  input  logic              palWrEn,
  input  logic [PAL_AW-1:0] palAddr,
  input  logic [WORD_W-1:0] palWrData,
  output logic [WORD_W-1:0] palRdData,
  output logic [OUT_W-1:0]  pixData,
  output logic              pixValid,
  input  logic              pixReady
);
  ctlStrobe_t strb;

  pix_unpack_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .cfgBppSel(cfgBppSel), .inValid(inValid),
    .inReady(inReady), .pixReady(pixReady), .pixValid(pixValid), .strb(strb)
  );

  pix_unpack_dp #(.IDX_W(IDX_W)) i_dp (
    .clk(clk), .cfgBppSel(cfgBppSel), .cfgByteBig(cfgByteBig), .cfgPixBig(cfgPixBig),
    .cfgSwapRB(cfgSwapRB), .inData(inData), .strb(strb), .palWrEn(palWrEn),
    .palAddr(palAddr), .palWrData(palWrData), .palRdData(palRdData), .pixData(pixData)
  );
endmodule

// File: rtl/pix_unpack_chk.sv
module pix_unpack_chk (
  input logic        clk,
  input logic        rstN,
  input logic [2:0]  cfgBppSel,
  input logic        inValid,
  input logic        inReady,
  input logic [23:0] pixData,
  input logic        pixValid,
  input logic        pixReady
);
  logic [6:0] pending;
  logic [6:0] perWord;
  logic       inFire;
  logic       pixFire;

  assign inFire  = inValid && inReady;
  assign pixFire = pixValid && pixReady;
  assign perWord = (cfgBppSel > 3'd4) ? 7'd1 : (7'd32 >> cfgBppSel);

  always_ff @(posedge clk) begin
    if (!rstN) pending <= '0;
    else pending <= pending + (inFire ? perWord : 7'd0) - (pixFire ? 7'd1 : 7'd0);
  end

  AST_STALL_VALID: assert property (@(posedge clk) disable iff (!rstN)
    pixValid && !pixReady |=> pixValid); // R10
  AST_STALL_DATA: assert property (@(posedge clk) disable iff (!rstN)
    pixValid && !pixReady |=> $stable(pixData)); // R10
  AST_POP_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    inFire |-> pending <= 7'd2); // R10
  AST_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rstN)
    pixFire |-> pending != 7'd0); // R1
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !pixValid && inReady); // R11
endmodule

bind pix_unpack pix_unpack_chk i_chk (
  .clk(clk), .rstN(rstN), .cfgBppSel(cfgBppSel), .inValid(inValid), .inReady(inReady),
  .pixData(pixData), .pixValid(pixValid), .pixReady(pixReady)
);

// File: tb/test_pix_unpack.sv
module test_pix_unpack;
  logic        clk = 1'b0;
  logic        rstN;
  logic [2:0]  cfgBppSel;
  logic        cfgByteBig, cfgPixBig, cfgSwapRB;
  logic [31:0] inData;
  logic        inValid;
  logic        inReady;
  logic        palWrEn;
  logic [6:0]  palAddr;
  logic [31:0] palWrData;
  logic [31:0] palRdData;
  logic [23:0] pixData;
  logic        pixValid;
  logic        pixReady;

  int nChecks = 0;
  int nFails = 0;

  always #2.5 clk = ~clk;

  pix_unpack i_pix_unpack (
    .clk(clk), .rstN(rstN), .cfgBppSel(cfgBppSel), .cfgByteBig(cfgByteBig),
    .cfgPixBig(cfgPixBig), .cfgSwapRB(cfgSwapRB), .inData(inData), .inValid(inValid),
    .inReady(inReady), .palWrEn(palWrEn), .palAddr(palAddr), .palWrData(palWrData),
    .palRdData(palRdData), .pixData(pixData), .pixValid(pixValid), .pixReady(pixReady)
  );

  function automatic logic [31:0] palWord(int a);
    logic [31:0] h;
    h = (32'(a) * 32'h9E3779B1) ^ (32'(a) << 17) ^ 32'h5A5A1234;
    return {h[31:16], h[15:0] ^ 16'h8421};
  endfunction

  function automatic logic [31:0] hashWord(int n);
    logic [31:0] h;
    h = (32'(n) + 32'h1234567) * 32'h85EBCA6B;
    return h ^ (h >> 13);
  endfunction

  function automatic logic [7:0] widen(logic [4:0] c);
    return 8'(int'(c) * 8 + int'(c) / 4);
  endfunction

  function automatic logic [23:0] expPix(logic [31:0] w, int sel, bit bb, bit pb, bit sw, int k);
    logic [31:0] o;
    logic [31:0] pw;
    logic [15:0] e;
    logic [7:0]  r, g, b, by;
    int bpp, ppb, j, pos, idx;
    o = bb ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
    bpp = (sel <= 4) ? (1 << sel) : 24;
    if (bpp <= 8) begin
      ppb = 8 / bpp;
      by  = o[8*(k/ppb) +: 8];
      j   = k % ppb;
      pos = (pb && bpp < 8) ? (ppb - 1 - j) * bpp : j * bpp;
      idx = (int'(by) >> pos) & ((1 << bpp) - 1);
      pw  = palWord(idx / 2);
      e   = (idx % 2 == 1) ? pw[31:16] : pw[15:0];
    end else begin
      e = o[16*k +: 16];
    end
    if (bpp == 24) begin
      r = o[7:0]; g = o[15:8]; b = o[23:16];
    end else begin
      r = widen(e[4:0]); g = widen(e[9:5]); b = widen(e[14:10]);
    end
    return sw ? {b, g, r} : {r, g, b};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    nChecks++;
    if (act !== expv) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] words [4];
    logic [23:0] expv [128];
    int total, sent, got, cyc;
    bit fireIn, fireOut;
    string tag;

    rstN = 1'b0; cfgBppSel = 3'd0; cfgByteBig = 0; cfgPixBig = 0; cfgSwapRB = 0;
    inData = '0; inValid = 0; palWrEn = 0; palAddr = '0; palWrData = '0; pixReady = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 pixValid", 32'(pixValid), 32'd0);
    check("R11 inReady", 32'(inReady), 32'd1);

    // R9: fill the palette, then read every word back
    for (int a = 0; a < 128; a++) begin
      palWrEn = 1'b1; palAddr = 7'(a); palWrData = palWord(a);
      @(negedge clk);
    end
    palWrEn = 1'b0;
    for (int a = 0; a < 128; a++) begin
      palAddr = 7'(a);
      @(negedge clk);
      check("R9 readback", palRdData, palWord(a));
    end

    for (int cfg = 0; cfg < 48; cfg++) begin
      int sel;
      bit bb, pb, sw;
      sel = cfg % 6; bb = ((cfg / 6) % 2) == 1; pb = ((cfg / 12) % 2) == 1; sw = ((cfg / 24) % 2) == 1;
      cfgBppSel = 3'(sel); cfgByteBig = bb; cfgPixBig = pb; cfgSwapRB = sw;
      if (sw) tag = "R8";
      else if (sel == 5) tag = "R7";
      else if (sel == 4) tag = "R6/R5";
      else if (sel < 3 && pb) tag = "R3/R4";
      else if (sel == 3 && pb) tag = "R3/R4/R5";
      else if (bb) tag = "R2/R4";
      else tag = "R1/R4/R5";
      total = 0;
      for (int w = 0; w < 4; w++) begin
        int ppw;
        words[w] = hashWord(cfg * 4 + w);
        ppw = (sel <= 4) ? (32 >> sel) : 1;
        for (int k = 0; k < ppw; k++) begin
          expv[total] = expPix(words[w], sel, bb, pb, sw, k);
          total++;
        end
      end
      sent = 0; got = 0; cyc = 0; fireIn = 0; fireOut = 0;
      while ((got < total || sent < 4) && cyc < 3000) begin
        @(negedge clk);
        if (fireIn) sent++;
        inValid  = (sent < 4) && (((cyc + cfg) % 3) != 1);
        inData   = words[(sent < 4) ? sent : 0];
        pixReady = ((cyc * 7 + cfg) % 5) != 0;
        #1;
        fireIn  = inValid && inReady;
        fireOut = pixValid && pixReady;
        if (fireOut) begin
          if (got < total) check(tag, 32'(pixData), 32'(expv[got]));
          got++;
        end
        cyc++;
      end
      @(negedge clk);
      inValid = 1'b0;
      pixReady = 1'b1;
      repeat (3) @(negedge clk);
      check("R10 pixel count", 32'(got), 32'(total));
      check("R10 no extra pixel", 32'(pixValid), 32'd0);
      pixReady = 1'b0;
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule